// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one capture channel of a timer. It watches an external pin and, when the chosen edge arrives, copies the value of a free-running counter into a capture register. It also raises a capture flag. An optional digital noise filter can be placed in front of the edge detector. The filter runs on the system clock and only passes a new pin level once that level has been seen on four consecutive clock samples.

Software selects which edge triggers a capture: rising or falling. It may change this choice between captures, for example to measure a duty cycle. Software clears the flag with a one-cycle strobe. The interrupt request is the flag gated by an enable. While the timer uses the capture register as its period limit, the channel makes no captures. The counter, its prescaler, the register interface and interrupt arbitration are all outside this block.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: With the filter off, a selected edge on `pin_i` loads `cap_o` with the value `cnt_i` holds at the third rising clock edge after the pin change. `flag_o` is set by that same edge, and not before it.
- R3: With `edge_rise_i`=1 only a 0-to-1 transition of the pin captures. With `edge_rise_i`=0 only a 1-to-0 transition captures. The other transition leaves `cap_o` and `flag_o` unchanged.
- R4: With `filt_en_i`=1, a new pin level is accepted only after it has been sampled on four consecutive system clock edges. A pulse held for three clock cycles causes no capture. A pulse held for four clock cycles causes a capture.
- R5: With `filt_en_i`=1, the capture happens exactly four clock cycles later than without the filter. This is the seventh rising edge after the pin change, and `cap_o` takes `cnt_i` from that edge.
- R6: A new capture overwrites `cap_o` even if `flag_o` is still set from an earlier capture.
- R7: A cycle with `flag_clr_i`=1 and no capture clears `flag_o` at the next clock edge.
- R8: If `flag_clr_i`=1 in the same cycle as a capture, the capture wins: `cap_o` loads and `flag_o` stays 1.
- R9: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R10: While `top_mode_i`=1, pin edges cause no capture: `cap_o` and `flag_o` do not change because of the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External capture pin (asynchronous) |
| cnt_i | input | CNT_W | Free-running timer counter value |
| edge_rise_i | input | 1 | 1: capture on the rising edge, 0: capture on the falling edge |
| filt_en_i | input | 1 | Enables the four-sample noise filter |
| flag_clr_i | input | 1 | Strobe that clears the capture flag |
| top_mode_i | input | 1 | Capture register serves as the counter's period; captures are suppressed |
| irq_en_i | input | 1 | Interrupt enable |
| cap_o | output | CNT_W | Captured counter value |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions watch several things on every cycle. They check that each internal capture event loads the counter value from the previous cycle and sets the flag. They check that a clear strobe without a capture drops the flag. They check that the capture register never moves while the period mode is active. They check that an interrupt request never appears without both the flag and the enable. Some behaviours can only be shown by bench scenarios, because they depend on how the pin evolves over several cycles. These are:
- the exact latency of three or seven edges;
- the rejection of a three-cycle pulse next to the acceptance of a four-cycle pulse;
- the edge-select polarity;
- the overwrite without a clear.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FILT_SAMPLES = 4;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned HIST_W = SAMPLES - 1;

  logic [HIST_W-1:0]  hist_q;
  logic [SAMPLES-1:0] win;
  logic               lvl_q;

  assign win = {hist_q, d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      hist_q <= win[HIST_W-1:0];
      if (&win)       lvl_q <= 1'b1;
      else if (~|win) lvl_q <= 1'b0;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  input  logic      active_i,
  output logic      evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    evt_o = 1'b0;
    if (active_i) begin
      unique case (sel_i)
        EDGE_RISE: evt_o = lvl_i & ~prev_q;
        EDGE_FALL: evt_o = ~lvl_i & prev_q;
        default:   evt_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  input  logic             flag_clr_i,
  input  logic             top_mode_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic             pin_sync;
  logic             pin_filt;
  logic             pin_lvl;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  edge_sel_e        sel;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  icap_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_sync),
    .q_o   (pin_filt)
  );

  assign pin_lvl = filt_en_i ? pin_filt : pin_sync;
  assign sel     = edge_rise_i ? EDGE_RISE : EDGE_FALL;

  icap_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (pin_lvl),
    .sel_i   (sel),
    .active_i(~top_mode_i),
    .evt_o   (cap_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= cnt_i;
      // capture has priority over clear
      if (cap_evt)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             flag_clr_i,
  input logic             top_mode_i,
  input logic             irq_en_i,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cap_o,
  input logic             flag_o,
  input logic             irq_o
);
  AST_CAP_LOADS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (cap_o == $past(cnt_i)) && flag_o); // R2

  AST_CLR_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !cap_evt) |=> !flag_o); // R7

  AST_CAP_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && cap_evt) |=> flag_o); // R8

  AST_TOP_HOLDS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_mode_i |=> $stable(cap_o)); // R10

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i)); // R9
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt_i),
  .flag_clr_i(flag_clr_i),
  .top_mode_i(top_mode_i),
  .irq_en_i  (irq_en_i),
  .cap_evt   (cap_evt),
  .cap_o     (cap_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pin = 1'b0;
  logic [CNT_W-1:0] cnt;
  logic             edge_rise = 1'b1;
  logic             filt_en = 1'b0;
  logic             flag_clr = 1'b0;
  logic             top_mode = 1'b0;
  logic             irq_en = 1'b0;
  logic [CNT_W-1:0] cap;
  logic             flag;
  logic             irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 16'h0100;
    else        cnt <= cnt + 16'd1;

  icap_unit #(.CNT_W(CNT_W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .cnt_i      (cnt),
    .edge_rise_i(edge_rise),
    .filt_en_i  (filt_en),
    .flag_clr_i (flag_clr),
    .top_mode_i (top_mode),
    .irq_en_i   (irq_en),
    .cap_o      (cap),
    .flag_o     (flag),
    .irq_o      (irq)
  );

  // {level, edge_rise, filt_en, expect_capture}
  typedef struct packed {
    logic lvl;
    logic rise;
    logic filt;
    logic exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
  endtask

  initial begin
    logic [CNT_W-1:0] c0;
    logic [CNT_W-1:0] prev_cap;
    int lat;
    cyc(2);
    check(cap == 0, "R1 cap", 32'(cap), 0);
    check(flag == 0, "R1 flag", 32'(flag), 0);
    check(irq == 0, "R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 R3 R5 vector walk
    foreach (VECS[k]) begin
      edge_rise = VECS[k].rise;
      filt_en   = VECS[k].filt;
      cyc(8);
      clear_flag();
      prev_cap = cap;
      c0  = cnt;
      pin = VECS[k].lvl;
      lat = VECS[k].filt ? 7 : 3;
      cyc(lat - 1);
      check(flag == 0, VECS[k].filt ? "R5 early" : "R2 early", 32'(flag), 0);
      cyc(1);
      check(flag == VECS[k].exp, "R3 flag", 32'(flag), 32'(VECS[k].exp));
      if (VECS[k].exp)
        check(cap == c0 + CNT_W'(lat - 1), VECS[k].filt ? "R5 cap" : "R2 cap",
              32'(cap), 32'(c0 + CNT_W'(lat - 1)));
      else
        check(cap == prev_cap, "R3 cap hold", 32'(cap), 32'(prev_cap));
      cyc(6);
    end

    // R4 glitch rejection / acceptance
    edge_rise = 1'b1;
    filt_en   = 1'b1;
    pin = 1'b0;
    cyc(10);
    clear_flag();
    prev_cap = cap;
    pin = 1'b1; cyc(3); pin = 1'b0;
    cyc(12);
    check(flag == 0, "R4 3-cycle pulse flag", 32'(flag), 0);
    check(cap == prev_cap, "R4 3-cycle pulse cap", 32'(cap), 32'(prev_cap));
    pin = 1'b1; cyc(4); pin = 1'b0;
    cyc(12);
    check(flag == 1, "R4 4-cycle pulse", 32'(flag), 1);

    // R6 overwrite without clear
    filt_en = 1'b0;
    cyc(10);
    clear_flag();
    pin = 1'b1; cyc(6); pin = 1'b0; cyc(6);
    c0 = cnt;
    pin = 1'b1;
    cyc(3);
    check(cap == c0 + 16'd2, "R6 overwrite", 32'(cap), 32'(c0 + 16'd2));
    check(flag == 1, "R6 flag", 32'(flag), 1);

    // R9 interrupt gating
    check(irq == 0, "R9 irq disabled", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    check(irq == 1, "R9 irq enabled", 32'(irq), 1);

    // R8 capture beats clear in the same cycle
    pin = 1'b0;
    cyc(6);
    c0 = cnt;
    pin = 1'b1;
    cyc(2);
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
    check(flag == 1, "R8 flag kept", 32'(flag), 1);
    check(cap == c0 + 16'd2, "R8 cap", 32'(cap), 32'(c0 + 16'd2));

    // R7 clear alone
    cyc(4);
    clear_flag();
    check(flag == 0, "R7 clear", 32'(flag), 0);
    check(irq == 0, "R9 irq after clear", 32'(irq), 0);

    // R10 suppression in period mode
    top_mode = 1'b1;
    prev_cap = cap;
    pin = 1'b0; cyc(6);
    pin = 1'b1; cyc(6);
    pin = 1'b0; cyc(6);
    pin = 1'b1; cyc(6);
    check(flag == 0, "R10 flag", 32'(flag), 0);
    check(cap == prev_cap, "R10 cap", 32'(cap), 32'(prev_cap));
    top_mode = 1'b0;
    cyc(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule